// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine

This block runs the enhanced-mode transfers of a parallel port. A processor reaches it over a simple register bus. An access to the address port at offset 3 performs one byte handshake using the address strobe. An access to the data port at offset 4 performs one or more byte handshakes using the data strobe. Each transfer runs only when the port's control byte, which a neighbouring block supplies, holds exactly the pattern for that direction. Any other access to those ports is dropped.

Every byte handshake follows the same four steps, and all the peripheral lines are active low:
1. The block asserts a strobe.
2. It waits for the peripheral to raise wait.
3. It releases the strobe.
4. It waits for wait to fall again.

A clock-counted window guards each step. If the window runs out, the block releases the strobe, abandons the rest of the access and sets a sticky timeout flag. The flag appears in bit 0 of status reads at offset 1, and a status write with bit 0 set clears it.

The block holds the bus until the whole access has finished, then pulses a ready signal for one cycle. Wide data-port accesses are split into byte handshakes, least significant byte first.

Top module: `epp_engine`

## Requirements
- R1: After reset the block is idle. All three strobes and the write line are high, `pd_oe` and `rsp_ready` are low, and a status read returns 0 in bit 0.
- R2: A write to offset 3 or 4 performs handshakes only when `ctrl_bits & 8'h2F == 8'h04`. Otherwise no strobe is asserted and the access completes with no effect.
- R3: A read from offset 3 or 4 performs handshakes only when `ctrl_bits & 8'h2F == 8'h24`. Otherwise no strobe is asserted and the read returns all ones at the access width (8'hFF, 16'hFFFF or 32'hFFFFFFFF), with zeros above that width.
- R4: Each byte handshake follows this order:
  - the strobe goes low;
  - the block waits for `n_wait` to go high;
  - the strobe returns high;
  - the block waits for `n_wait` to go low.

  Offset 3 uses `n_astrobe` and offset 4 uses `n_dstrobe`, and the two are never low together. During a write, `n_write` is low and `pd_oe` drives the byte on `pd_out`.
- R5: On the data port, `req_size` 0 moves 1 byte, 1 moves 2 bytes, and 2 or 3 moves 4 bytes. Bytes are transferred least significant first. The address port always moves one byte.
- R6: In a read, the byte latched from `pd_in` when `n_wait` rises during the k-th handshake becomes byte k of `rsp_rdata`.
- R7: A strobe or release phase may last at most `TIMEOUT_CYCLES` clocks. If it does not complete in that time:
  - the strobe is released;
  - the timeout flag is set;
  - the remaining bytes are skipped;
  - the access completes;
  - read bytes that were never received return as 8'hFF.
- R8: A read of offset 1 returns `ext_status` with bit 0 replaced by the timeout flag.
- R9: A write of offset 1 with bit 0 set clears the timeout flag. With bit 0 clear, the flag is unchanged.
- R10: When the acknowledge arrives in the last clock of a phase window, the handshake proceeds and no timeout is recorded.
- R11: `rsp_ready` is high for exactly one cycle per access. It comes only after every byte handshake of that access has completed or timed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held until `rsp_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register offset |
| req_size | input | 2 | Data-port width code |
| req_wdata | input | 32 | Write value |
| ctrl_bits | input | 8 | Current port control byte |
| ext_status | input | 8 | Current external status lines |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, valid with `rsp_ready` |
| pd_in | input | 8 | Data lines from peripheral |
| pd_out | output | 8 | Data lines to peripheral |
| pd_oe | output | 1 | Drive enable for `pd_out` |
| n_write | output | 1 | Active-low write cycle indicator |
| n_dstrobe | output | 1 | Active-low data strobe |
| n_astrobe | output | 1 | Active-low address strobe |
| n_wait | input | 1 | Peripheral acknowledge, active-low wait |

## Verification
The peripheral's acknowledge and the expiry of the phase window can land on the same clock edge. The bench forces this by setting the model's response delay equal to the window length, which puts the rise of `n_wait` exactly on the expiry edge. In that case the transfer must complete and the flag must stay clear. A second run with a delay one clock longer must end in a timeout, with the flag readable through the status port.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STROBE  = 2'd1,
    ST_RELEASE = 2'd2,
    ST_DONE    = 2'd3
  } epp_state_t;

  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_ADDR   = 3'd3;
  localparam logic [2:0] OFS_DATA   = 3'd4;

  localparam logic [7:0] CTL_MASK = 8'h2F;
  localparam logic [7:0] CTL_WR   = 8'h04;
  localparam logic [7:0] CTL_RD   = 8'h24;

  function automatic logic [31:0] width_ones(input logic [1:0] last_idx);
    case (last_idx)
      2'd0:    width_ones = 32'h0000_00FF;
      2'd1:    width_ones = 32'h0000_FFFF;
      default: width_ones = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/epp_qualify.sv
module epp_qualify
  import epp_pkg::*;
(
  input  logic [7:0] ctrl,
  output logic       wr_ok,
  output logic       rd_ok
);
  logic [7:0] masked;

  always_comb begin
    masked = ctrl & CTL_MASK;
    wr_ok  = (masked == CTL_WR);
    rd_ok  = (masked == CTL_RD);
  end
endmodule

// File: rtl/epp_timer.sv
module epp_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expire
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    expire = run && (cnt_q == LAST);
    cnt_d  = cnt_q;
    if (restart)               cnt_d = '0;
    else if (run && !expire)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: the window counter never runs past its limit
  p_window_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/epp_engine.sv
module epp_engine
  import epp_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [2:0]  req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  input  logic [7:0]  ctrl_bits,
  input  logic [7:0]  ext_status,
  output logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  input  logic [7:0]  pd_in,
  output logic [7:0]  pd_out,
  output logic        pd_oe,
  output logic        n_write,
  output logic        n_dstrobe,
  output logic        n_astrobe,
  input  logic        n_wait
);
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic wr_ok, rd_ok, tmr_expire, tmr_restart, tmr_run;

  epp_qualify u_qual (.ctrl(ctrl_bits), .wr_ok(wr_ok), .rd_ok(rd_ok));

  epp_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_s), .restart(tmr_restart), .run(tmr_run), .expire(tmr_expire)
  );

  epp_state_t  state_q, state_d;
  logic [1:0]  idx_q, idx_d, last_q, last_d;
  logic        is_wr_q, is_wr_d, is_addr_q, is_addr_d, flag_q, flag_d;
  logic [31:0] wdata_q, wdata_d, rdata_q, rdata_d;
  logic        port_hit, qualified;
  logic [1:0]  req_last;

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    last_d      = last_q;
    is_wr_d     = is_wr_q;
    is_addr_d   = is_addr_q;
    flag_d      = flag_q;
    wdata_d     = wdata_q;
    rdata_d     = rdata_q;
    tmr_restart = 1'b0;
    port_hit    = (req_addr == OFS_ADDR) || (req_addr == OFS_DATA);
    qualified   = req_write ? wr_ok : rd_ok;
    if (req_addr == OFS_ADDR) req_last = 2'd0;
    else if (req_size[1])     req_last = 2'd3;
    else if (req_size[0])     req_last = 2'd1;
    else                      req_last = 2'd0;

    case (state_q)
      ST_IDLE: if (req_valid) begin
        idx_d     = 2'd0;
        last_d    = req_last;
        is_wr_d   = req_write;
        is_addr_d = (req_addr == OFS_ADDR);
        wdata_d   = req_wdata;
        if (port_hit && !req_write)
          rdata_d = width_ones(req_last);
        else if (req_addr == OFS_STATUS && !req_write)
          rdata_d = {24'h0, ext_status[7:1], flag_q};
        else
          rdata_d = 32'h0;
        if (req_addr == OFS_STATUS && req_write && req_wdata[0])
          flag_d = 1'b0;
        if (port_hit && qualified) begin
          state_d     = ST_STROBE;
          tmr_restart = 1'b1;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_STROBE: begin
        if (n_wait) begin
          if (!is_wr_q) rdata_d[{idx_q, 3'b000} +: 8] = pd_in;
          state_d     = ST_RELEASE;
          tmr_restart = 1'b1;
        end else if (tmr_expire) begin
          flag_d  = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_RELEASE: begin
        if (!n_wait) begin
          if (idx_q == last_q) begin
            state_d = ST_DONE;
          end else begin
            idx_d       = idx_q + 2'd1;
            state_d     = ST_STROBE;
            tmr_restart = 1'b1;
          end
        end else if (tmr_expire) begin
          flag_d  = 1'b1;
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q   <= ST_IDLE;
      idx_q     <= 2'd0;
      last_q    <= 2'd0;
      is_wr_q   <= 1'b0;
      is_addr_q <= 1'b0;
      flag_q    <= 1'b0;
      wdata_q   <= 32'h0;
      rdata_q   <= 32'h0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      last_q    <= last_d;
      is_wr_q   <= is_wr_d;
      is_addr_q <= is_addr_d;
      flag_q    <= flag_d;
      wdata_q   <= wdata_d;
      rdata_q   <= rdata_d;
    end
  end

  logic busy;
  always_comb begin
    busy      = (state_q == ST_STROBE) || (state_q == ST_RELEASE);
    tmr_run   = busy;
    n_dstrobe = !((state_q == ST_STROBE) && !is_addr_q);
    n_astrobe = !((state_q == ST_STROBE) && is_addr_q);
    n_write   = !(busy && is_wr_q);
    pd_oe     = busy && is_wr_q;
    pd_out    = wdata_q[{idx_q, 3'b000} +: 8];
    rsp_ready = (state_q == ST_DONE);
    rsp_rdata = rdata_q;
  end

  // R4: the two strobes are never asserted together
  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_s)
    !(!n_dstrobe && !n_astrobe));
  // R4: a strobe released without expiry must follow an acknowledge
  p_release_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_s)
    ($rose(n_dstrobe) && !$past(tmr_expire)) |-> $past(n_wait));
  // R2/R3: an unqualified request never asserts a strobe
  p_unqualified_quiet_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_IDLE && req_valid && !(port_hit && qualified)) |=> (n_dstrobe && n_astrobe));
  // R7: the sticky flag only rises from a window expiry
  p_flag_from_expiry_r7: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(flag_q) |-> $past(tmr_expire));
  // R9: writing 1 to status bit 0 clears the flag
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_IDLE && req_valid && req_write && req_addr == OFS_STATUS && req_wdata[0]) |=> !flag_q);
  // R11: completion is a single-cycle pulse
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_s)
    rsp_ready |=> !rsp_ready);
endmodule

// File: tb/epp_engine_bench.sv
module epp_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [2:0]  req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic [7:0]  ctrl_bits, ext_status;
  logic        rsp_ready;
  logic [31:0] rsp_rdata;
  logic [7:0]  pd_in, pd_out;
  logic        pd_oe, n_write, n_dstrobe, n_astrobe;
  logic        n_wait;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  epp_engine #(.TIMEOUT_CYCLES(TMO)) u_epp_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .ctrl_bits(ctrl_bits), .ext_status(ext_status), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
    .n_write(n_write), .n_dstrobe(n_dstrobe), .n_astrobe(n_astrobe), .n_wait(n_wait)
  );

  // peripheral model
  int       ack_dly = 2;
  bit       fail_en = 1'b0;
  int       fail_byte = 0;
  int       dly = 0;
  int       byte_cnt = 0;
  int       stb_starts = 0;
  int       order_err = 0;
  bit       prev_stb = 1'b0;
  logic [7:0] cap [0:7];
  bit       cap_astb [0:7];
  bit       cap_nwr [0:7];
  bit       cap_oe [0:7];
  logic [7:0] rd_base = 8'h50;

  assign pd_in = rd_base + 8'(byte_cnt);

  always @(negedge clk) begin
    bit stb;
    if (rst_n) begin
      stb = !n_dstrobe || !n_astrobe;
      if (stb && !prev_stb) stb_starts++;
      if (!stb && prev_stb && !n_wait && !fail_en) order_err++;
      prev_stb = stb;
      if (stb && !n_wait) begin
        if (!(fail_en && byte_cnt == fail_byte)) begin
          dly++;
          if (dly >= ack_dly) begin
            n_wait = 1'b1;
            cap[byte_cnt]      = pd_out;
            cap_astb[byte_cnt] = !n_astrobe;
            cap_nwr[byte_cnt]  = n_write;
            cap_oe[byte_cnt]   = pd_oe;
            dly = 0;
          end
        end
      end else if (!stb && n_wait) begin
        dly++;
        if (dly >= ack_dly) begin
          n_wait = 1'b0;
          byte_cnt++;
          dly = 0;
        end
      end else begin
        dly = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset(input int d);
    ack_dly = d; fail_en = 1'b0; byte_cnt = 0; stb_starts = 0; order_err = 0;
  endtask

  int last_cycles;
  task automatic access(input bit wr, input logic [2:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    n = 0;
    do begin @(negedge clk); n++; end while (!rsp_ready && n < 500);
    rd = rsp_rdata;
    last_cycles = n;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!rsp_ready, "R11 ready single pulse", 32'(rsp_ready), 0);
  endtask

  task automatic test_reset();
    logic [31:0] r;
    chk(n_dstrobe && n_astrobe && n_write && !pd_oe && !rsp_ready, "R1 idle pins",
        {n_dstrobe, n_astrobe, n_write, pd_oe, rsp_ready}, 5'b11100);
    ext_status = 8'hA6;
    access(1'b0, 3'd1, 2'd0, 0, r);
    chk(r == 32'hA6, "R1 flag clear after reset", r, 32'hA6);
  endtask

  task automatic test_addr_write();
    logic [31:0] r;
    model_reset(2); ctrl_bits = 8'hC4;
    access(1'b1, 3'd3, 2'd2, 32'h0000_0091, r);
    chk(stb_starts == 1 && cap[0] == 8'h91 && cap_astb[0], "R4 address write strobe/data",
        {cap_astb[0], cap[0]}, 9'h191);
    chk(!cap_nwr[0] && cap_oe[0] && order_err == 0, "R4 write line and order", order_err, 0);
  endtask

  task automatic test_data_write_word();
    logic [31:0] r;
    model_reset(3); ctrl_bits = 8'h04;
    access(1'b1, 3'd4, 2'd2, 32'h4433_2211, r);
    chk(stb_starts == 4, "R5 four byte cycles", stb_starts, 4);
    chk({cap[3], cap[2], cap[1], cap[0]} == 32'h4433_2211 && !cap_astb[0],
        "R5 LSB first on data strobe", {cap[3], cap[2], cap[1], cap[0]}, 32'h4433_2211);
    model_reset(1);
    access(1'b1, 3'd4, 2'd1, 32'hFFFF_BEEF, r);
    chk(stb_starts == 2 && cap[0] == 8'hEF && cap[1] == 8'hBE, "R5 halfword write",
        {cap[1], cap[0]}, 16'hBEEF);
  endtask

  task automatic test_write_ignored();
    logic [31:0] r;
    model_reset(2); ctrl_bits = 8'h05;
    access(1'b1, 3'd4, 2'd0, 32'h77, r);
    chk(stb_starts == 0 && last_cycles <= 2, "R2 write ignored, strobe bit set", stb_starts, 0);
    ctrl_bits = 8'h24;
    access(1'b1, 3'd3, 2'd0, 32'h77, r);
    chk(stb_starts == 0, "R2 write ignored in read direction", stb_starts, 0);
  endtask

  task automatic test_reads();
    logic [31:0] r;
    model_reset(2); ctrl_bits = 8'hE4; rd_base = 8'h50;
    access(1'b0, 3'd4, 2'd2, 0, r);
    chk(r == 32'h5352_5150, "R6 word read assembly", r, 32'h5352_5150);
    model_reset(1);
    access(1'b0, 3'd4, 2'd1, 0, r);
    chk(r == 32'h0000_5150, "R6 halfword read", r, 32'h0000_5150);
    model_reset(1);
    access(1'b0, 3'd3, 2'd2, 0, r);
    chk(r == 32'h50 && stb_starts == 1 && cap_astb[0], "R4 address read one byte", r, 32'h50);
  endtask

  task automatic test_read_ignored();
    logic [31:0] r;
    model_reset(1); ctrl_bits = 8'h04;
    access(1'b0, 3'd4, 2'd2, 0, r);
    chk(r == 32'hFFFF_FFFF && stb_starts == 0, "R3 word read ignored", r, 32'hFFFF_FFFF);
    ctrl_bits = 8'h2C;
    access(1'b0, 3'd4, 2'd1, 0, r);
    chk(r == 32'h0000_FFFF, "R3 halfword read ignored", r, 32'h0000_FFFF);
    access(1'b0, 3'd3, 2'd0, 0, r);
    chk(r == 32'h0000_00FF && stb_starts == 0, "R3 byte read ignored", r, 32'hFF);
  endtask

  task automatic test_timeout_and_status();
    logic [31:0] r;
    model_reset(1); ctrl_bits = 8'h24; rd_base = 8'h50;
    fail_en = 1'b1; fail_byte = 2;
    access(1'b0, 3'd4, 2'd2, 0, r);
    chk(r == 32'hFFFF_5150, "R7 partial read keeps ones", r, 32'hFFFF_5150);
    chk(stb_starts == 3, "R7 remaining bytes aborted", stb_starts, 3);
    chk(n_dstrobe, "R7 strobe released", 32'(n_dstrobe), 1);
    fail_en = 1'b0;
    ext_status = 8'hA6;
    access(1'b0, 3'd1, 2'd0, 0, r);
    chk(r == 32'hA7, "R8 flag in status bit 0", r, 32'hA7);
    access(1'b1, 3'd1, 2'd0, 32'h0000_00FE, r);
    access(1'b0, 3'd1, 2'd0, 0, r);
    chk(r == 32'hA7, "R9 write of 0 keeps flag", r, 32'hA7);
    access(1'b1, 3'd1, 2'd0, 32'h0000_0001, r);
    ext_status = 8'h5B;
    access(1'b0, 3'd1, 2'd0, 0, r);
    chk(r == 32'h5A, "R9 flag cleared, R8 bit replaced", r, 32'h5A);
  endtask

  task automatic test_window_edge();
    logic [31:0] r;
    model_reset(TMO); ctrl_bits = 8'h04;
    access(1'b1, 3'd4, 2'd0, 32'h3C, r);
    access(1'b0, 3'd1, 2'd0, 0, r);
    chk(r[0] == 1'b0 && cap[0] == 8'h3C, "R10 ack on last window cycle wins", r, 32'h5A);
    model_reset(TMO + 1); ctrl_bits = 8'h04;
    access(1'b1, 3'd4, 2'd0, 32'h3C, r);
    chk(stb_starts == 1, "R7 one late byte attempt", stb_starts, 1);
    access(1'b0, 3'd1, 2'd0, 0, r);
    chk(r[0] == 1'b1, "R7 late ack times out", r, 32'h5B);
    access(1'b1, 3'd1, 2'd0, 32'h1, r);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = 3'd0; req_size = 2'd0;
    req_wdata = 32'h0; ctrl_bits = 8'hCC; ext_status = 8'h00; n_wait = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    test_reset();
    test_addr_write();
    test_data_write_word();
    test_write_ignored();
    test_reads();
    test_read_ignored();
    test_timeout_and_status();
    test_window_edge();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule